// File: doc/BRIEF.md
# Serial Register and Scratch-RAM Access Port

This block is the serial slave front end of a clock/calendar device. It holds a small memory map with two regions. The first is a 32-byte bank of clock/calendar registers at addresses 0x00 to 0x1F. The second is a 64-byte scratch RAM at 0x20 to 0x5F. A host starts a transaction by pulling chip-select low. It shifts in an opcode byte and an address byte, most significant bit first. It then either clocks read data out of the block or shifts write data into it, for as many bytes as it likes. The transaction ends when chip-select rises.

After each data byte the internal pointer moves to the next address. The pointer stays inside the region where the burst began: a register burst goes round the 32 registers, and a RAM burst goes round the 64 RAM bytes. A separate opcode clears the whole RAM to zero. While the battery-mode input is high the port refuses all traffic.

The serial pins are sampled in the `clk` domain and must be synchronous to it. `sck` must stay high for at least one `clk` cycle and low for at least one `clk` cycle. The serial data path has no valid/ready handshake, because the host's clock paces it. The block cannot push back. A byte is accepted on its eighth rising `sck` edge. The next read byte is already loaded when the following falling edge arrives. The output pad is split into a data pin and an output-enable pin, so the tri-state buffer sits outside the block.

Top module: `rtc_spi_port`

## Requirements
- R1: `so_oe` is 0 after reset, whenever `cs_n` is high, and during the opcode and address bytes of every transaction.
- R2: Opcode 0x13 reads. After the address byte, the byte at that address is driven on `so_d`, MSB first. Its first bit is valid after the falling `sck` edge that follows the 16th rising edge. Further bytes follow for as long as `sck` toggles.
- R3: Opcode 0x12 writes with no prior enable. Every complete data byte shifted in after the address is stored at the pointer.
- R4: The pointer advances by one after each data byte. A burst that starts at 0x20 to 0x5F wraps from 0x5F to 0x20.
- R5: A burst that starts at 0x00 to 0x1F wraps from 0x1F to 0x00 and never touches RAM.
- R6: If `cs_n` rises before the eighth bit of a write data byte, that partial byte is discarded. Complete bytes before it are kept.
- R7: Opcode 0x54 sets all 64 RAM bytes to 0x00 and leaves the registers unchanged.
- R8: While `batt_mode` is 1, no transaction reads or writes: `so_oe` stays 0 and no storage changes.
- R9: Any other opcode causes the rest of the transaction to be ignored until `cs_n` rises.
- R10: An address above 0x5F causes the rest of the transaction to be ignored: no output and no write.
- R11: `so_d` changes only on the `clk` cycle that follows a detected falling `sck` edge while output is enabled.
- R12: `si` is ignored during the read data phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the serial pins are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| si | input | 1 | Serial data in |
| batt_mode | input | 1 | High while running from backup supply; blocks access |
| so_d | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for the external tri-state SO pad |

## Verification
Most internal faults are visible at the ports within one byte time. A wrong phase counter shifts read data by whole bits, and the MSB-first byte on `so_d` shows it at once. A pointer that wraps wrongly writes into the wrong region. That only appears when a later read burst crosses the boundary, so the wrap tests write across the edge and then read back both the wrapped-to byte and the byte just outside the region. A faulty enable or commit gate shows up as `so_oe` high when it should be low, or as a changed byte on the next read.

// File: rtl/rtc_spi_pkg.sv
package rtc_spi_pkg;
  localparam logic [7:0] OP_READ  = 8'h13;
  localparam logic [7:0] OP_WRITE = 8'h12;
  localparam logic [7:0] OP_CLEAR = 8'h54;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_RD,
    PH_WR,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/rtc_spi_ptr.sv
module rtc_spi_ptr #(
  parameter int AW        = 8,
  parameter int REG_BYTES = 32,
  parameter int RAM_BYTES = 64
) (
  input  logic [AW-1:0] cur,
  input  logic          in_ram,
  output logic [AW-1:0] nxt
);
  localparam logic [AW-1:0] REG_LAST = AW'(REG_BYTES - 1);
  localparam logic [AW-1:0] RAM_BASE = AW'(REG_BYTES);
  localparam logic [AW-1:0] RAM_LAST = AW'(REG_BYTES + RAM_BYTES - 1);

  always_comb begin
    if (in_ram)
      nxt = (cur == RAM_LAST) ? RAM_BASE : cur + 1'b1;
    else
      nxt = (cur == REG_LAST) ? '0 : cur + 1'b1;
  end
endmodule

// File: rtl/rtc_spi_mem.sv
module rtc_spi_mem #(
  parameter int AW        = 8,
  parameter int REG_BYTES = 32,
  parameter int RAM_BYTES = 64
) (
  input  logic          clk,
  input  logic          we,
  input  logic          clr,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = REG_BYTES + RAM_BYTES;

  logic [DEPTH*8-1:0] cells;

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (we && waddr == AW'(i))
        cells[i*8 +: 8] <= wdata;
      else if (clr && i >= REG_BYTES)
        cells[i*8 +: 8] <= 8'h00;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (int'(raddr) < DEPTH)
      rdata = cells[int'(raddr)*8 +: 8];
  end
endmodule

// File: rtl/rtc_spi_port.sv
module rtc_spi_port
  import rtc_spi_pkg::*;
#(
  parameter int AW        = 8,
  parameter int REG_BYTES = 32,
  parameter int RAM_BYTES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic batt_mode,
  output logic so_d,
  output logic so_oe
);
  localparam logic [AW-1:0] RAM_BASE = AW'(REG_BYTES);
  localparam logic [AW-1:0] TOP_ADDR = AW'(REG_BYTES + RAM_BYTES - 1);

  phase_t        phase;
  logic [2:0]    bitcnt;
  logic [6:0]    shreg;
  logic          op_wr;
  logic [AW-1:0] ptr;
  logic [AW-1:0] ptr_nxt;
  logic          in_ram;
  logic          sck_q;
  logic          so_q;
  logic [7:0]    rd_byte;

  logic       sck_rise, sck_fall, byte_end;
  logic [7:0] byte_in;
  logic       mem_we, mem_clr, ptr_live;

  assign sck_rise = ~cs_n & sck & ~sck_q;
  assign sck_fall = ~cs_n & ~sck & sck_q;
  assign byte_end = sck_rise && bitcnt == 3'd7;
  assign byte_in  = {shreg, si};
  assign mem_we   = byte_end && phase == PH_WR && !batt_mode;
  assign mem_clr  = byte_end && phase == PH_CMD && byte_in == OP_CLEAR && !batt_mode;
  assign ptr_live = ~cs_n && (phase == PH_RD || phase == PH_WR);

  rtc_spi_ptr #(.AW(AW), .REG_BYTES(REG_BYTES), .RAM_BYTES(RAM_BYTES)) u_ptr (
    .cur(ptr), .in_ram(in_ram), .nxt(ptr_nxt)
  );

  rtc_spi_mem #(.AW(AW), .REG_BYTES(REG_BYTES), .RAM_BYTES(RAM_BYTES)) u_mem (
    .clk(clk), .we(mem_we), .clr(mem_clr), .waddr(ptr), .wdata(byte_in),
    .raddr(ptr), .rdata(rd_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_CMD;
      bitcnt <= '0;
      shreg  <= '0;
      op_wr  <= 1'b0;
      ptr    <= '0;
      in_ram <= 1'b0;
      sck_q  <= 1'b0;
      so_q   <= 1'b0;
    end else begin
      sck_q <= sck;
      if (cs_n) begin
        phase  <= PH_CMD;
        bitcnt <= '0;
      end else begin
        if (sck_rise) begin
          bitcnt <= bitcnt + 1'b1;
          shreg  <= byte_in[6:0];
        end
        if (byte_end) begin
          unique case (phase)
            PH_CMD: begin
              if (batt_mode)                 phase <= PH_SKIP;
              else if (byte_in == OP_READ)  begin phase <= PH_ADDR; op_wr <= 1'b0; end
              else if (byte_in == OP_WRITE) begin phase <= PH_ADDR; op_wr <= 1'b1; end
              else                           phase <= PH_SKIP;
            end
            PH_ADDR: begin
              if (batt_mode || byte_in > TOP_ADDR) phase <= PH_SKIP;
              else begin
                ptr    <= byte_in;
                in_ram <= byte_in >= RAM_BASE;
                phase  <= op_wr ? PH_WR : PH_RD;
              end
            end
            PH_RD, PH_WR: ptr <= ptr_nxt;
            default: ;
          endcase
        end
        if (sck_fall && phase == PH_RD)
          so_q <= rd_byte[3'd7 - bitcnt];
      end
    end
  end

  assign so_oe = ~cs_n && phase == PH_RD && !batt_mode;
  assign so_d  = so_q;
endmodule

// File: rtl/rtc_spi_port_chk.sv
module rtc_spi_port_chk #(
  parameter int AW        = 8,
  parameter int REG_BYTES = 32,
  parameter int RAM_BYTES = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          sck,
  input logic          so_d,
  input logic          so_oe,
  input logic          mem_we,
  input logic          mem_clr,
  input logic          ptr_live,
  input logic          in_ram,
  input logic [AW-1:0] ptr
);
  localparam int RAM_LO = REG_BYTES;
  localparam int RAM_HI = REG_BYTES + RAM_BYTES - 1;

  logic sck_prev;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sck_prev <= 1'b0;
    else        sck_prev <= sck;

  wire fall_seen = ~cs_n & sck_prev & ~sck;

  // R4
  ram_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_live && in_ram) |-> (int'(ptr) >= RAM_LO && int'(ptr) <= RAM_HI));

  // R5
  reg_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_live && !in_ram) |-> (int'(ptr) < REG_BYTES));

  // R11
  so_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (so_oe && !fall_seen) |=> (!so_oe || $stable(so_d)));

  // R3
  commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R7
  clear_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_clr |-> !mem_we);
endmodule

bind rtc_spi_port rtc_spi_port_chk #(.AW(AW), .REG_BYTES(REG_BYTES), .RAM_BYTES(RAM_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .so_d(so_d), .so_oe(so_oe),
  .mem_we(mem_we), .mem_clr(mem_clr), .ptr_live(ptr_live), .in_ram(in_ram), .ptr(ptr)
);

// File: tb/rtc_spi_port_tb.sv
module rtc_spi_port_tb;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0, batt_mode = 1'b0;
  logic so_d, so_oe;
  int errors = 0, checks = 0;

  rtc_spi_port u_dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
                      .batt_mode(batt_mode), .so_d(so_d), .so_oe(so_oe));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output logic oe_any);
    oe_any = 1'b0;
    for (int b = 7; b >= 0; b--) begin
      si = tx[b];
      repeat (2) @(negedge clk);
      rx[b] = so_d;
      oe_any |= so_oe;
      sck = 1'b1;
      repeat (2) @(negedge clk);
      sck = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic start();
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic stop();
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic write_burst(input logic [7:0] addr, input logic [7:0] d0, input logic [7:0] d1,
                             input int n);
    logic [7:0] rx; logic oe;
    start();
    xfer(8'h12, rx, oe); xfer(addr, rx, oe);
    xfer(d0, rx, oe);
    if (n > 1) xfer(d1, rx, oe);
    stop();
  endtask

  // returns the first byte; r1 is the second byte of the burst
  task automatic read2(input logic [7:0] addr, output logic [7:0] r0, output logic [7:0] r1,
                       output logic hdr_oe, output logic dat_oe);
    logic [7:0] rx; logic oe, oe2;
    start();
    xfer(8'h13, rx, hdr_oe); xfer(addr, rx, oe);
    hdr_oe |= oe;
    xfer(8'hFF, r0, dat_oe); xfer(8'hA5, r1, oe2);
    dat_oe &= oe2;
    stop();
  endtask

  task automatic t_reset();
    chk(so_oe == 1'b0, "R1 reset so_oe", so_oe, 0);
  endtask

  task automatic t_basic();
    logic [7:0] a, b; logic h, d;
    write_burst(8'h24, 8'h3C, 8'hC3, 2);
    read2(8'h24, a, b, h, d);
    chk(a == 8'h3C, "R3 R2 first byte", a, 8'h3C);
    chk(b == 8'hC3, "R4 second byte", b, 8'hC3);
    chk(h == 1'b0, "R1 hi-Z in header", h, 0);
    chk(d == 1'b1, "R2 so_oe in data", d, 1);
    chk(so_oe == 1'b0, "R1 cs high", so_oe, 0);
    read2(8'h24, a, b, h, d);
    chk(a == 8'h3C && b == 8'hC3, "R12 si ignored in read", {a, b}, 16'h3CC3);
  endtask

  task automatic t_ram_wrap();
    logic [7:0] a, b; logic h, d;
    write_burst(8'h5F, 8'h11, 8'h22, 2);
    read2(8'h5F, a, b, h, d);
    chk(a == 8'h11, "R4 byte at 5F", a, 8'h11);
    chk(b == 8'h22, "R4 wrap to 20", b, 8'h22);
  endtask

  task automatic t_reg_wrap();
    logic [7:0] a, b; logic h, d;
    write_burst(8'h20, 8'h77, 8'h00, 1);
    write_burst(8'h1F, 8'h5A, 8'hA5, 2);
    read2(8'h1F, a, b, h, d);
    chk(a == 8'h5A, "R5 byte at 1F", a, 8'h5A);
    chk(b == 8'hA5, "R5 wrap to 00", b, 8'hA5);
    read2(8'h20, a, b, h, d);
    chk(a == 8'h77, "R5 RAM untouched", a, 8'h77);
  endtask

  task automatic t_partial();
    logic [7:0] rx, a, b; logic oe, h, d;
    write_burst(8'h30, 8'h01, 8'h02, 2);
    start();
    xfer(8'h12, rx, oe); xfer(8'h30, rx, oe); xfer(8'hE7, rx, oe);
    for (int k = 0; k < 4; k++) begin
      si = 1'b1; repeat (2) @(negedge clk);
      sck = 1'b1; repeat (2) @(negedge clk);
      sck = 1'b0; repeat (2) @(negedge clk);
    end
    stop();
    read2(8'h30, a, b, h, d);
    chk(a == 8'hE7, "R6 full byte kept", a, 8'hE7);
    chk(b == 8'h02, "R6 partial dropped", b, 8'h02);
  endtask

  task automatic t_clear();
    logic [7:0] rx, a, b; logic oe, h, d;
    start(); xfer(8'h54, rx, oe); stop();
    read2(8'h5F, a, b, h, d);
    chk(a == 8'h00 && b == 8'h00, "R7 RAM cleared", {a, b}, 0);
    read2(8'h1F, a, b, h, d);
    chk(a == 8'h5A && b == 8'hA5, "R7 registers kept", {a, b}, 16'h5AA5);
  endtask

  task automatic t_batt();
    logic [7:0] rx, a, b; logic oe, h, d;
    batt_mode = 1'b1;
    write_burst(8'h40, 8'h99, 8'h98, 2);
    start(); xfer(8'h54, rx, oe); stop();
    read2(8'h1F, a, b, h, d);
    chk(d == 1'b0 && h == 1'b0, "R8 so_oe low in battery", d, 0);
    batt_mode = 1'b0;
    write_burst(8'h1F, 8'h5A, 8'h00, 1);
    read2(8'h40, a, b, h, d);
    chk(a == 8'h00 && b == 8'h00, "R8 write refused", {a, b}, 0);
  endtask

  task automatic t_bad_op();
    logic [7:0] rx, a, b; logic oe, oe_all;
    start();
    xfer(8'h03, rx, oe_all); xfer(8'h40, rx, oe); oe_all |= oe;
    xfer(8'h66, rx, oe); oe_all |= oe;
    stop();
    chk(oe_all == 1'b0, "R9 no output", oe_all, 0);
    begin logic h, d; read2(8'h40, a, b, h, d); end
    chk(a == 8'h00, "R9 no write", a, 0);
  endtask

  task automatic t_bad_addr();
    logic [7:0] a, b; logic h, d;
    read2(8'h60, a, b, h, d);
    chk(d == 1'b0, "R10 no output", d, 0);
    write_burst(8'h80, 8'h44, 8'h00, 1);
    read2(8'h00, a, b, h, d);
    chk(a == 8'hA5, "R10 no write wrap", a, 8'hA5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_ram_wrap();
    t_reg_wrap();
    t_partial();
    t_clear();
    t_batt();
    t_bad_op();
    t_bad_addr();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule